// File: doc/BRIEF.md
# Radio Packet FIFO Sequencer

This block carries whole packets between local logic and the packet FIFOs of a radio transceiver. It reaches the transceiver only through an external single-byte access engine. For each access it issues one request: short or long address space, read or write, a 10-bit address and a write byte. The engine answers with a one-cycle completion strobe, and for reads it returns a data byte with that strobe.

To send a packet, the host pulses `tx_start` with a length and then offers payload bytes on a valid/ready stream. The sequencer writes a zero header length, then the payload length, then each payload byte into the transmit FIFO. It finishes by writing the trigger register, which starts transmission. To receive, the host pulses `rx_poll`. The sequencer reads the interrupt status register. When the packet-present flag is set, it reads the stored length and the trailing link-quality and signal-strength bytes. It then reads every payload byte so that the FIFO is drained. Bytes that fit the local limit are streamed out, and a completion pulse reports the length and the two quality bytes.

Top module: `pkt_fifo_seq`

## Requirements
- R1: A transmit starts with a long-space write of 0x00 to address 0x000, followed by a long-space write of the requested length to address 0x001.
- R2: Payload byte i is taken from the stream on a cycle where `tx_valid` and `tx_ready` are both high. It is written to long address 0x002+i in ascending order of i, and only one byte is accepted per write.
- R3: After the last payload byte is written (or right after the length write when the length is 0), the short-space register 0x1B is written with 0x01. `tx_done` pulses for one cycle on the cycle after that write completes.
- R4: A receive poll first reads short register 0x31. If bit 3 of the value is clear, no further access is made. `rx_done` then pulses with `rx_len`, `rx_lqi` and `rx_rssi` all 0.
- R5: When bit 3 is set, the sequencer reads long addresses in this order: 0x300 (giving the length L), 0x301+L (link quality), 0x302+L (signal strength), and then 0x301+i for every i from 0 to L-1 in ascending order.
- R6: For each payload index i below MAX_LEN, the byte read is presented on `rx_data` with `rx_valid` high for one cycle, on the cycle after its read completes. `rx_last` is set on the final byte presented. Bytes at index MAX_LEN or above are read but not presented.
- R7: `rx_done` pulses on the cycle after the final access of a receive. `rx_len` equals L when L < MAX_LEN and 0 otherwise. `rx_lqi` and `rx_rssi` hold the bytes read for that packet.
- R8: At most one access is outstanding. `acc_req` and all of its fields stay stable until `acc_done`, and `acc_req` is low on the cycle after `acc_done`.
- R9: Only one operation runs at a time. `tx_start` and `rx_poll` are ignored while `busy` is high. When both are pulsed in the same idle cycle, the transmit runs and the poll is dropped.
- R10: While reset is applied, `busy`, `acc_req`, `tx_ready`, `rx_valid`, `rx_done` and `tx_done` are low, and `rx_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Start a transmit (one-cycle pulse) |
| tx_len | input | 8 | Payload length for the transmit |
| tx_valid | input | 1 | Payload byte offered |
| tx_data | input | 8 | Payload byte |
| tx_ready | output | 1 | Sequencer takes a payload byte |
| tx_done | output | 1 | Transmit trigger written (pulse) |
| rx_poll | input | 1 | Start a receive poll (one-cycle pulse) |
| rx_valid | output | 1 | Received payload byte present (pulse) |
| rx_data | output | 8 | Received payload byte |
| rx_last | output | 1 | Final presented byte of the packet |
| rx_done | output | 1 | Receive poll finished (pulse) |
| rx_len | output | 8 | Reported length, 0 when no packet or too long |
| rx_lqi | output | 8 | Link-quality byte of the packet |
| rx_rssi | output | 8 | Signal-strength byte of the packet |
| busy | output | 1 | An operation is in progress |
| acc_req | output | 1 | Access request to the engine |
| acc_long | output | 1 | 1 = long address space, 0 = short |
| acc_wr | output | 1 | 1 = write, 0 = read |
| acc_addr | output | 10 | Register or FIFO address |
| acc_wdata | output | 8 | Write byte |
| acc_done | input | 1 | Access completed (one-cycle strobe) |
| acc_rdata | input | 8 | Read byte, valid with acc_done |

## Verification
The checker assumes that the engine raises `acc_done` only while `acc_req` is high, and for a single cycle per request. It also assumes that the host sends start pulses of one cycle and holds a payload byte until it is accepted. The bench engine model answers at the first falling edge after it sees a request and clears the strobe at the next one. The host tasks raise each start and each byte strobe for exactly one cycle. The tasks that deliberately issue a start while an operation is running still keep within these assumptions, because the design must ignore that start.

// File: rtl/pkt_seq_pkg.sv
package pkt_seq_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;

  // fixed FIFO and register locations
  localparam logic [ADDR_W-1:0] TX_HLEN_A = 10'h000;
  localparam logic [ADDR_W-1:0] TX_PLEN_A = 10'h001;
  localparam logic [ADDR_W-1:0] TX_PAY_A  = 10'h002;
  localparam logic [ADDR_W-1:0] RX_LEN_A  = 10'h300;
  localparam logic [ADDR_W-1:0] RX_PAY_A  = 10'h301;
  localparam logic [ADDR_W-1:0] TRIG_A    = 10'h01B;
  localparam logic [ADDR_W-1:0] STAT_A    = 10'h031;
  localparam int               STAT_BIT  = 3;

  typedef struct packed {
    logic              req;
    logic              lng;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } acc_req_t;
endpackage

// File: rtl/pkt_tx_ctrl.sv
module pkt_tx_ctrl
  import pkt_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [LEN_W-1:0]  len,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_in,
  output logic              byte_rdy,
  output acc_req_t          acc,
  input  logic              acc_done,
  output logic              busy,
  output logic              done
);
  typedef enum logic [2:0] {T_IDLE, T_HDR, T_LEN, T_GET, T_PUT, T_TRIG} tst_e;

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  tst_e              st_q, st_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [LEN_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              req_q, req_d;
  logic              done_q, done_d;
  logic              in_acc;

  assign in_acc = (st_q == T_HDR) || (st_q == T_LEN) || (st_q == T_PUT) || (st_q == T_TRIG);

  always_comb begin
    st_d   = st_q;
    len_d  = len_q;
    idx_d  = idx_q;
    byte_d = byte_q;
    req_d  = req_q;
    done_d = 1'b0;
    if (st_q == T_IDLE) begin
      if (go) begin
        len_d = len;
        idx_d = '0;
        st_d  = T_HDR;
      end
    end else if (st_q == T_GET) begin
      if (byte_vld) begin
        byte_d = byte_in;
        st_d   = T_PUT;
      end
    end else if (in_acc) begin
      if (!req_q) begin
        req_d = 1'b1;
      end else if (acc_done) begin
        req_d = 1'b0;
        case (st_q)
          T_HDR:   st_d = T_LEN;
          T_LEN:   st_d = (len_q == '0) ? T_TRIG : T_GET;
          T_PUT: begin
            idx_d = idx_q + ONE;
            st_d  = (idx_q == len_q - ONE) ? T_TRIG : T_GET;
          end
          T_TRIG: begin
            st_d   = T_IDLE;
            done_d = 1'b1;
          end
          default: st_d = T_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= T_IDLE;
      len_q  <= '0;
      idx_q  <= '0;
      byte_q <= '0;
      req_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      len_q  <= len_d;
      idx_q  <= idx_d;
      byte_q <= byte_d;
      req_q  <= req_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    acc.req   = req_q;
    acc.wr    = 1'b1;
    acc.lng   = (st_q != T_TRIG);
    acc.addr  = TX_HLEN_A;
    acc.wdata = '0;
    case (st_q)
      T_LEN: begin
        acc.addr  = TX_PLEN_A;
        acc.wdata = DATA_W'(len_q);
      end
      T_PUT: begin
        acc.addr  = TX_PAY_A + ADDR_W'(idx_q);
        acc.wdata = byte_q;
      end
      T_TRIG: begin
        acc.addr  = TRIG_A;
        acc.wdata = DATA_W'(1);
      end
      default: ;
    endcase
  end

  assign byte_rdy = (st_q == T_GET);
  assign busy     = (st_q != T_IDLE);
  assign done     = done_q;
endmodule

// File: rtl/pkt_rx_ctrl.sv
module pkt_rx_ctrl
  import pkt_seq_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int MAX_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output acc_req_t          acc,
  input  logic              acc_done,
  input  logic [DATA_W-1:0] acc_rdata,
  output logic              busy,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              done,
  output logic [LEN_W-1:0]  rep_len,
  output logic [DATA_W-1:0] lqi,
  output logic [DATA_W-1:0] rssi
);
  typedef enum logic [2:0] {R_IDLE, R_STAT, R_LEN, R_LQI, R_RSSI, R_PAY} rst_e;

  localparam logic [LEN_W:0]   MAXV = (LEN_W+1)'(MAX_LEN);
  localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);

  rst_e              st_q, st_d;
  logic [LEN_W-1:0]  plen_q, plen_d;
  logic [LEN_W-1:0]  idx_q, idx_d;
  logic              req_q, req_d;
  logic              done_q, done_d;
  logic              vld_q, vld_d;
  logic              last_q, last_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [LEN_W-1:0]  rlen_q, rlen_d;
  logic [DATA_W-1:0] lqi_q, lqi_d;
  logic [DATA_W-1:0] rssi_q, rssi_d;
  logic              fits;
  logic              keep;
  logic [LEN_W-1:0]  last_idx;

  assign fits     = ({1'b0, plen_q} < MAXV);
  assign keep     = ({1'b0, idx_q} < MAXV);
  assign last_idx = fits ? (plen_q - ONE) : LEN_W'(MAX_LEN - 1);

  always_comb begin
    st_d   = st_q;
    plen_d = plen_q;
    idx_d  = idx_q;
    req_d  = req_q;
    done_d = 1'b0;
    vld_d  = 1'b0;
    last_d = 1'b0;
    data_d = data_q;
    rlen_d = rlen_q;
    lqi_d  = lqi_q;
    rssi_d = rssi_q;
    if (st_q == R_IDLE) begin
      if (go) st_d = R_STAT;
    end else if (!req_q) begin
      req_d = 1'b1;
    end else if (acc_done) begin
      req_d = 1'b0;
      case (st_q)
        R_STAT: begin
          if (acc_rdata[STAT_BIT]) begin
            st_d = R_LEN;
          end else begin
            st_d   = R_IDLE;
            done_d = 1'b1;
            rlen_d = '0;
            lqi_d  = '0;
            rssi_d = '0;
          end
        end
        R_LEN: begin
          plen_d = LEN_W'(acc_rdata);
          st_d   = R_LQI;
        end
        R_LQI: begin
          lqi_d = acc_rdata;
          st_d  = R_RSSI;
        end
        R_RSSI: begin
          rssi_d = acc_rdata;
          idx_d  = '0;
          if (plen_q == '0) begin
            st_d   = R_IDLE;
            done_d = 1'b1;
            rlen_d = '0;
          end else begin
            st_d = R_PAY;
          end
        end
        R_PAY: begin
          if (keep) begin
            vld_d  = 1'b1;
            data_d = acc_rdata;
            last_d = (idx_q == last_idx);
          end
          idx_d = idx_q + ONE;
          if (idx_q == plen_q - ONE) begin
            st_d   = R_IDLE;
            done_d = 1'b1;
            rlen_d = fits ? plen_q : '0;
          end
        end
        default: st_d = R_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= R_IDLE;
      plen_q <= '0;
      idx_q  <= '0;
      req_q  <= 1'b0;
      done_q <= 1'b0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      data_q <= '0;
      rlen_q <= '0;
      lqi_q  <= '0;
      rssi_q <= '0;
    end else begin
      st_q   <= st_d;
      plen_q <= plen_d;
      idx_q  <= idx_d;
      req_q  <= req_d;
      done_q <= done_d;
      vld_q  <= vld_d;
      last_q <= last_d;
      data_q <= data_d;
      rlen_q <= rlen_d;
      lqi_q  <= lqi_d;
      rssi_q <= rssi_d;
    end
  end

  always_comb begin
    acc.req   = req_q;
    acc.wr    = 1'b0;
    acc.wdata = '0;
    acc.lng   = (st_q != R_STAT);
    case (st_q)
      R_STAT:  acc.addr = STAT_A;
      R_LEN:   acc.addr = RX_LEN_A;
      R_LQI:   acc.addr = RX_PAY_A + ADDR_W'(plen_q);
      R_RSSI:  acc.addr = RX_PAY_A + ADDR_W'(plen_q) + ADDR_W'(1);
      R_PAY:   acc.addr = RX_PAY_A + ADDR_W'(idx_q);
      default: acc.addr = '0;
    endcase
  end

  assign busy     = (st_q != R_IDLE);
  assign out_vld  = vld_q;
  assign out_data = data_q;
  assign out_last = last_q;
  assign done     = done_q;
  assign rep_len  = rlen_q;
  assign lqi      = lqi_q;
  assign rssi     = rssi_q;
endmodule

// File: rtl/pkt_acc_mux.sv
module pkt_acc_mux
  import pkt_seq_pkg::*;
(
  input  acc_req_t          tx_acc,
  input  acc_req_t          rx_acc,
  input  logic              sel_rx,
  input  logic              done_in,
  output logic              tx_done,
  output logic              rx_done,
  output logic              req,
  output logic              lng,
  output logic              wr,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);
  acc_req_t pick;

  assign pick    = sel_rx ? rx_acc : tx_acc;
  assign req     = pick.req;
  assign lng     = pick.lng;
  assign wr      = pick.wr;
  assign addr    = pick.addr;
  assign wdata   = pick.wdata;
  assign tx_done = done_in & ~sel_rx;
  assign rx_done = done_in & sel_rx;
endmodule

// File: rtl/pkt_fifo_seq.sv
module pkt_fifo_seq
  import pkt_seq_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int MAX_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              tx_done,
  input  logic              rx_poll,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_last,
  output logic              rx_done,
  output logic [LEN_W-1:0]  rx_len,
  output logic [DATA_W-1:0] rx_lqi,
  output logic [DATA_W-1:0] rx_rssi,
  output logic              busy,
  output logic              acc_req,
  output logic              acc_long,
  output logic              acc_wr,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_wdata,
  input  logic              acc_done,
  input  logic [DATA_W-1:0] acc_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  logic       tx_busy, rx_busy;
  logic       tx_go, rx_go;
  logic       tx_ack, rx_ack;
  acc_req_t   tx_acc, rx_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign busy  = tx_busy | rx_busy;
  assign tx_go = tx_start & ~busy;
  assign rx_go = rx_poll & ~busy & ~tx_start;

  pkt_tx_ctrl #(.LEN_W(LEN_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .go       (tx_go),
    .len      (tx_len),
    .byte_vld (tx_valid),
    .byte_in  (tx_data),
    .byte_rdy (tx_ready),
    .acc      (tx_acc),
    .acc_done (tx_ack),
    .busy     (tx_busy),
    .done     (tx_done)
  );

  pkt_rx_ctrl #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_rx (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .go        (rx_go),
    .acc       (rx_acc),
    .acc_done  (rx_ack),
    .acc_rdata (acc_rdata),
    .busy      (rx_busy),
    .out_vld   (rx_valid),
    .out_data  (rx_data),
    .out_last  (rx_last),
    .done      (rx_done),
    .rep_len   (rx_len),
    .lqi       (rx_lqi),
    .rssi      (rx_rssi)
  );

  pkt_acc_mux u_mux (
    .tx_acc  (tx_acc),
    .rx_acc  (rx_acc),
    .sel_rx  (rx_busy),
    .done_in (acc_done),
    .tx_done (tx_ack),
    .rx_done (rx_ack),
    .req     (acc_req),
    .lng     (acc_long),
    .wr      (acc_wr),
    .addr    (acc_addr),
    .wdata   (acc_wdata)
  );
endmodule

// File: rtl/pkt_fifo_seq_chk.sv
module pkt_fifo_seq_chk
  import pkt_seq_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int MAX_LEN = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              tx_done,
  input logic              rx_valid,
  input logic              rx_last,
  input logic              rx_done,
  input logic [LEN_W-1:0]  rx_len,
  input logic              busy,
  input logic              acc_req,
  input logic              acc_long,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] acc_wdata,
  input logic              acc_done
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_done |=> acc_req && $stable(acc_addr) && $stable(acc_wdata)
                             && $stable(acc_wr) && $stable(acc_long));

  // R8
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_done |=> !acc_req);

  // R3
  tx_done_after_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(acc_req && acc_done && acc_wr && !acc_long && acc_addr == TRIG_A));

  // R2
  tx_one_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready && tx_valid |=> !tx_ready);

  // R6
  rx_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_last |-> rx_valid);

  // R7
  rx_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> ({1'b0, rx_len} < (LEN_W+1)'(MAX_LEN)));

  // R9
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_done && rx_done));

  // R9
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> busy);
endmodule

bind pkt_fifo_seq pkt_fifo_seq_chk #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_i_n),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_done   (tx_done),
  .rx_valid  (rx_valid),
  .rx_last   (rx_last),
  .rx_done   (rx_done),
  .rx_len    (rx_len),
  .busy      (busy),
  .acc_req   (acc_req),
  .acc_long  (acc_long),
  .acc_wr    (acc_wr),
  .acc_addr  (acc_addr),
  .acc_wdata (acc_wdata),
  .acc_done  (acc_done)
);

// File: tb/pkt_fifo_seq_tb.sv
module pkt_fifo_seq_tb;
  localparam int MAXL = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_start, tx_valid, rx_poll, acc_done;
  logic [7:0] tx_len, tx_data, acc_rdata;
  logic       tx_ready, tx_done, rx_valid, rx_last, rx_done, busy;
  logic       acc_req, acc_long, acc_wr;
  logic [7:0] rx_data, rx_len, rx_lqi, rx_rssi, acc_wdata;
  logic [9:0] acc_addr;

  int n_vec = 0;
  int n_bad = 0;

  logic [19:0] exp_acc[$];
  string       exp_tag[$];
  logic [8:0]  exp_rx[$];
  logic [7:0]  lmem[1024];
  logic [7:0]  smem[64];
  logic [7:0]  e_len, e_lqi, e_rssi;
  logic        tx_seen, rx_seen;

  always #10 clk = ~clk;

  pkt_fifo_seq #(.LEN_W(8), .MAX_LEN(MAXL)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_len(tx_len),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .tx_done(tx_done),
    .rx_poll(rx_poll), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_done(rx_done), .rx_len(rx_len), .rx_lqi(rx_lqi), .rx_rssi(rx_rssi),
    .busy(busy), .acc_req(acc_req), .acc_long(acc_long), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_done(acc_done),
    .acc_rdata(acc_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_acc(input logic wr, input logic lng, input int addr,
                          input logic [7:0] d, input string tag);
    exp_acc.push_back({wr, lng, 10'(addr), wr ? d : 8'h00});
    exp_tag.push_back(tag);
  endtask

  // engine model and access monitor
  initial begin
    acc_done  = 1'b0;
    acc_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (acc_done) begin
        acc_done = 1'b0;
      end else if (acc_req) begin
        logic [19:0] got;
        got = {acc_wr, acc_long, acc_addr, acc_wr ? acc_wdata : 8'h00};
        if (exp_acc.size() == 0) begin
          check("R9 unexpected access", 32'(got), 32'hFFFFF);
        end else begin
          check({exp_tag.pop_front(), " access"}, 32'(got), 32'(exp_acc.pop_front()));
        end
        if (acc_wr && acc_long) lmem[acc_addr] = acc_wdata;
        acc_rdata = acc_long ? lmem[acc_addr] : smem[acc_addr[5:0]];
        acc_done  = 1'b1;
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rx_valid) begin
        if (exp_rx.size() == 0) check("R6 extra byte", {23'd0, rx_last, rx_data}, 32'h1FF);
        else check("R6 rx byte/last", {23'd0, rx_last, rx_data}, 32'(exp_rx.pop_front()));
      end
      if (rx_done) begin
        check("R7 rx_len", 32'(rx_len), 32'(e_len));
        check("R7 rx_lqi", 32'(rx_lqi), 32'(e_lqi));
        check("R7 rx_rssi", 32'(rx_rssi), 32'(e_rssi));
        rx_seen = 1'b1;
      end
      if (tx_done) tx_seen = 1'b1;
    end
  end

  task automatic run_tx(input int len, input int seed, input logic poll_too, input logic poll_mid);
    push_acc(1, 1, 'h000, 8'h00, "R1");
    push_acc(1, 1, 'h001, 8'(len), "R1");
    for (int i = 0; i < len; i++) push_acc(1, 1, 'h002 + i, 8'(seed + 7*i), "R2");
    push_acc(1, 0, 'h01B, 8'h01, "R3");
    tx_seen = 1'b0;
    rx_seen = 1'b0;
    @(negedge clk);
    tx_start = 1'b1; tx_len = 8'(len); rx_poll = poll_too;
    @(negedge clk);
    tx_start = 1'b0; rx_poll = 1'b0;
    if (poll_mid) begin
      rx_poll = 1'b1;
      @(negedge clk);
      rx_poll = 1'b0;
    end
    for (int i = 0; i < len; i++) begin
      while (!tx_ready) @(negedge clk);
      tx_valid = 1'b1; tx_data = 8'(seed + 7*i);
      @(negedge clk);
      tx_valid = 1'b0;
    end
    while (!tx_seen) @(negedge clk);
    repeat (6) @(negedge clk);
    check("R3 tx accesses left", 32'(exp_acc.size()), 32'd0);
    check("R9 poll ignored during tx", 32'(rx_seen), 32'd0);
  endtask

  task automatic run_rx(input int len, input logic [7:0] stat, input logic [7:0] q,
                        input logic [7:0] s, input logic tx_mid);
    logic present;
    int   nkeep;
    present = stat[3];
    smem[6'h31] = stat;
    lmem[10'h300] = 8'(len);
    for (int i = 0; i < len; i++) lmem[10'(32'h301 + i)] = 8'(8'hA0 ^ (3*i));
    lmem[10'(32'h301 + len)] = q;
    lmem[10'(32'h302 + len)] = s;
    push_acc(0, 0, 'h031, 8'h00, "R4");
    if (present) begin
      push_acc(0, 1, 'h300, 8'h00, "R5");
      push_acc(0, 1, 'h301 + len, 8'h00, "R5");
      push_acc(0, 1, 'h302 + len, 8'h00, "R5");
      for (int i = 0; i < len; i++) push_acc(0, 1, 'h301 + i, 8'h00, "R5");
    end
    nkeep = (len < MAXL) ? len : MAXL;
    if (present)
      for (int i = 0; i < nkeep; i++)
        exp_rx.push_back({(i == nkeep - 1), 8'(8'hA0 ^ (3*i))});
    e_len  = (present && len < MAXL) ? 8'(len) : 8'h00;
    e_lqi  = present ? q : 8'h00;
    e_rssi = present ? s : 8'h00;
    rx_seen = 1'b0;
    tx_seen = 1'b0;
    @(negedge clk);
    rx_poll = 1'b1;
    @(negedge clk);
    rx_poll = 1'b0;
    if (tx_mid) begin
      tx_start = 1'b1; tx_len = 8'd2;
      @(negedge clk);
      tx_start = 1'b0;
    end
    while (!rx_seen) @(negedge clk);
    repeat (6) @(negedge clk);
    check("R5 rx accesses left", 32'(exp_acc.size()), 32'd0);
    check("R6 rx bytes left", 32'(exp_rx.size()), 32'd0);
    check("R9 start ignored during rx", 32'(tx_seen), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) lmem[i] = 8'h00;
    for (int i = 0; i < 64; i++) smem[i] = 8'h00;
    rst_n = 1'b0; tx_start = 1'b0; tx_valid = 1'b0; rx_poll = 1'b0;
    tx_len = 8'h00; tx_data = 8'h00;
    e_len = 8'h00; e_lqi = 8'h00; e_rssi = 8'h00;
    tx_seen = 1'b0; rx_seen = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy", 32'(busy), 32'd0);
    check("R10 acc_req", 32'(acc_req), 32'd0);
    check("R10 tx_ready", 32'(tx_ready), 32'd0);
    check("R10 rx_valid", 32'(rx_valid), 32'd0);
    check("R10 rx_done", 32'(rx_done), 32'd0);
    check("R10 tx_done", 32'(tx_done), 32'd0);
    check("R10 rx_len", 32'(rx_len), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_tx(3, 8'h11, 1'b0, 1'b0);            // R1 R2 R3 basic
    run_tx(0, 8'h00, 1'b0, 1'b0);            // R3 zero length
    run_tx(1, 8'h5C, 1'b1, 1'b1);            // R9 tx wins, poll ignored while busy
    run_rx(5, 8'hF7, 8'h33, 8'h44, 1'b0);    // R4 bit 3 clear, other bits set
    run_rx(5, 8'h08, 8'h6A, 8'h9B, 1'b0);    // R5 R6 R7 short packet
    run_rx(0, 8'h08, 8'h12, 8'h34, 1'b0);    // R7 empty packet
    run_rx(MAXL - 1, 8'h0C, 8'h21, 8'h43, 1'b0); // R7 largest reported
    run_rx(MAXL, 8'h08, 8'h55, 8'h66, 1'b0); // R6 R7 length at limit
    run_rx(20, 8'h08, 8'h77, 8'h88, 1'b1);   // R6 truncation, R9 tx ignored
    run_tx(4, 8'hE0, 1'b0, 1'b0);            // R2 after receives

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule